// File: doc/BRIEF.md
# Adaptive Decision-Feedback LMS Equalizer

This block removes linear inter-symbol interference from a real-valued stream of multi-level symbols, one symbol per clock. A transversal filter over recent input samples and a second transversal filter over past reference symbols are combined: the forward sum minus the feedback sum gives the equalized sample. A slicer rounds that sample to the nearest odd-integer level, and a mux picks the reference symbol: the training symbol when one is supplied, otherwise the slicer's own decision.

Every coefficient of both filters has its own least-mean-square update, so all taps adapt in the same clock in which their error is formed. Adaptation can be frozen while filtering continues. A pulse returns the taps to a pass-through state, and single taps can be overwritten through an index-plus-data write port. Tap counts, sample and coefficient widths and the position of the centre tap are parameters.

Samples are signed fixed point with `FRAC` fractional bits, so one symbol unit is `2**FRAC`. Coefficients are signed with `CFRAC` fractional bits, so unity is `2**CFRAC`.

Top module: `dfe_lms_eq`

## Requirements
- R1: After reset, the centre forward tap is unity and all other taps are zero. The equalized output `y_out` then equals the input sample taken `CENTER+1` clocks earlier.
- R2: `y_out` is `(sum cf[k]*xd[k] - sum cb[j]*rd[j]) >>> CFRAC`, with the shift rounding toward minus infinity. Here `xd[k]` is the input registered `k+1` clocks ago and `rd[j]` is the reference symbol registered `j+1` clocks ago.
- R3: The decision is `2*floor(y/2)+1` in symbol units, clamped to `±(L-1)`. The mode `lvl_sel` selects L: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16 levels.
- R4: When `trn_vld` is high, the reference is `trn_sym` and `err_out` equals `trn_sym - y_out`.
- R5: When `trn_vld` is low, the reference is the decision and `err_out` equals `dec_out - y_out`. Once the filter has converged, the decisions reproduce the transmitted symbols.
- R6: With `frz_n` high, each clock sets `cf[k] += (err*xd[k]) >> s` and `cb[j] -= (err*rd[j]) >> s`, where `s = 2*FRAC-CFRAC+mu_sh`, the shift rounds to nearest and the result saturates to the coefficient width. On a two-path channel with training, the mean squared error converges to below 0.01 symbol².
- R7: While `frz_n` is low, no coefficient changes, whatever the error, and filtering continues.
- R8: `init` has priority over writes and adaptation. It restores the state of R1 in the next clock.
- R9: A write with `wr_en` high loads `wr_data` into forward tap `wr_idx` when `wr_idx < NFF`, and otherwise into feedback tap `wr_idx-NFF`. It takes priority over adaptation.
- R10: `y_out` saturates to the signed `DW`-bit range when the filter sum exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | DW | Incoming sample, signed, FRAC fractional bits |
| trn_sym | input | DW | Training symbol aligned with the current output |
| trn_vld | input | 1 | Training symbol valid; selects it as reference |
| lvl_sel | input | 2 | Slicer level mode (2/4/8/16) |
| mu_sh | input | MUW | Extra right shift applied to the LMS step |
| frz_n | input | 1 | Active-low freeze of all coefficients |
| init | input | 1 | Restore pass-through coefficients |
| wr_en | input | 1 | Coefficient write strobe |
| wr_idx | input | IW | Coefficient index, forward taps first |
| wr_data | input | CW | Coefficient value, CFRAC fractional bits |
| y_out | output | DW | Equalized sample |
| dec_out | output | DW | Slicer decision |
| err_out | output | DW+1 | Reference minus equalized sample |

## Verification
The bench builds the block with five forward taps, three feedback taps and the centre at tap 2. With taps this few, the expected output of R2 can be formed in closed form from the bench's own record of the written coefficients. It also lets a frozen pass-through filter sweep every third input code across the whole 12-bit range in all four slicer modes. The short lines make a two-path channel with a half-amplitude echo converge within a few thousand symbols, so that convergence, the later decision-directed run and the return to pass-through on `init` are all covered.

// File: rtl/dfe_lms_eq.sv
module dfe_lms_eq #(
  parameter int NFF    = 64,
  parameter int NFB    = 192,
  parameter int CENTER = NFF / 2,
  parameter int DW     = 12,
  parameter int FRAC   = 6,
  parameter int CW     = 16,
  parameter int CFRAC  = 12,
  parameter int MUW    = 4,
  parameter int IW     = $clog2(NFF + NFB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] trn_sym,
  input  logic                 trn_vld,
  input  logic [1:0]           lvl_sel,
  input  logic [MUW-1:0]       mu_sh,
  input  logic                 frz_n,
  input  logic                 init,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic signed [CW-1:0] wr_data,
  output logic signed [DW-1:0] y_out,
  output logic signed [DW-1:0] dec_out,
  output logic signed [DW:0]   err_out
);
  localparam int ACCW = DW + CW + $clog2(NFF + NFB) + 1;
  localparam int UW   = 2 * DW + CW + 3;
  localparam int SH0  = 2 * FRAC - CFRAC;
  localparam logic signed [CW-1:0]   ONE  = CW'(1 << CFRAC);
  localparam logic signed [ACCW-1:0] YMAX = ACCW'(2 ** (DW - 1) - 1);
  localparam logic signed [ACCW-1:0] YMIN = -ACCW'(2 ** (DW - 1));
  localparam logic signed [UW-1:0]   CMAX = UW'(2 ** (CW - 1) - 1);
  localparam logic signed [UW-1:0]   CMIN = -UW'(2 ** (CW - 1));

  logic signed [DW-1:0]   xd  [NFF];
  logic signed [DW-1:0]   rd  [NFB];
  logic signed [CW-1:0]   cff [NFF];
  logic signed [CW-1:0]   cfb [NFB];
  logic signed [ACCW-1:0] acc, yf;
  logic signed [DW-1:0]   y, dec, rsym;
  logic signed [DW:0]     err;
  int                     t, lev, lim, sh;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NFF; k++) acc = acc + ACCW'(cff[k]) * ACCW'(xd[k]);
    for (int j = 0; j < NFB; j++) acc = acc - ACCW'(cfb[j]) * ACCW'(rd[j]);
  end

  assign yf = acc >>> CFRAC;
  assign y  = (yf > YMAX) ? YMAX[DW-1:0] : (yf < YMIN) ? YMIN[DW-1:0] : yf[DW-1:0];

  always_comb begin
    t   = int'(y) >>> (FRAC + 1);
    lim = (2 << lvl_sel) - 1;
    lev = 2 * t + 1;
    if (lev > lim) lev = lim;
    if (lev < -lim) lev = -lim;
    dec = DW'(lev * (1 << FRAC));
  end

  assign rsym = trn_vld ? trn_sym : dec;
  assign err  = {rsym[DW-1], rsym} - {y[DW-1], y};
  assign sh   = SH0 + int'(mu_sh);

  function automatic logic signed [CW-1:0] lms(input logic signed [CW-1:0] c,
      input logic signed [DW-1:0] v, input logic signed [DW:0] e, input int s, input logic neg);
    logic signed [UW-1:0] p, r, n;
    p = UW'(e) * UW'(v);
    r = (UW'(1) <<< s) >>> 1;
    p = (p + r) >>> s;
    n = neg ? UW'(c) - p : UW'(c) + p;
    if (n > CMAX) n = CMAX;
    if (n < CMIN) n = CMIN;
    return n[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NFF; k++) begin
        xd[k]  <= '0;
        cff[k] <= (k == CENTER) ? ONE : '0;
      end
      for (int j = 0; j < NFB; j++) begin
        rd[j]  <= '0;
        cfb[j] <= '0;
      end
    end else begin
      xd[0] <= x_in;
      for (int k = 1; k < NFF; k++) xd[k] <= xd[k-1];
      rd[0] <= rsym;
      for (int j = 1; j < NFB; j++) rd[j] <= rd[j-1];
      if (init) begin
        for (int k = 0; k < NFF; k++) cff[k] <= (k == CENTER) ? ONE : '0;
        for (int j = 0; j < NFB; j++) cfb[j] <= '0;
      end else if (wr_en) begin
        for (int k = 0; k < NFF; k++) if (int'(wr_idx) == k) cff[k] <= wr_data;
        for (int j = 0; j < NFB; j++) if (int'(wr_idx) == NFF + j) cfb[j] <= wr_data;
      end else if (frz_n) begin
        for (int k = 0; k < NFF; k++) cff[k] <= lms(cff[k], xd[k], err, sh, 1'b0);
        for (int j = 0; j < NFB; j++) cfb[j] <= lms(cfb[j], rd[j], err, sh, 1'b1);
      end
    end
  end

  assign y_out   = y;
  assign dec_out = dec;
  assign err_out = err;

  p_init_center_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> cff[CENTER] == ONE);
  p_init_fb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> cfb[0] == '0);
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_n && !init && !wr_en) |=> ($stable(cff[CENTER]) && $stable(cfb[0])));
  p_write_tap0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init && wr_idx == '0) |=> cff[0] == $past(wr_data));
  p_dec_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out[FRAC] && dec_out[FRAC-1:0] == '0);
endmodule

// File: tb/dfe_lms_eq_tb.sv
module dfe_lms_eq_tb;
  localparam int NFF = 5, NFB = 3, C = 2, DW = 12, FRAC = 6, CW = 16, CFRAC = 12, MUW = 4;
  localparam int IW = $clog2(NFF + NFB);
  localparam int HN = 20000;

  logic clk = 0, rst_n = 0;
  logic signed [DW-1:0] x_in = 0, trn_sym = 0;
  logic trn_vld = 0, frz_n = 0, init = 0, wr_en = 0;
  logic [1:0] lvl_sel = 2'd2;
  logic [MUW-1:0] mu_sh = 4'd9;
  logic [IW-1:0] wr_idx = 0;
  logic signed [CW-1:0] wr_data = 0;
  logic signed [DW-1:0] y_out, dec_out;
  logic signed [DW:0] err_out;

  int checks = 0, errors = 0, idx = 0, px = 0, pr = 0;
  int xh [HN];
  int rh [HN];
  int bcf [NFF];
  int bcb [NFB];
  int sv [HN];
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  dfe_lms_eq #(.NFF(NFF), .NFB(NFB), .CENTER(C), .DW(DW), .FRAC(FRAC), .CW(CW),
               .CFRAC(CFRAC), .MUW(MUW)) u_dut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .trn_sym(trn_sym), .trn_vld(trn_vld),
    .lvl_sel(lvl_sel), .mu_sh(mu_sh), .frz_n(frz_n), .init(init), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .y_out(y_out), .dec_out(dec_out), .err_out(err_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int xv(input int k);
    return (idx - 1 - k >= 0) ? xh[idx-1-k] : 0;
  endfunction

  function automatic int rv(input int j);
    return (idx - 1 - j >= 0) ? rh[idx-1-j] : 0;
  endfunction

  function automatic int sat(input longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return int'(v);
  endfunction

  function automatic int yexp();
    longint a = 0;
    for (int k = 0; k < NFF; k++) a += longint'(bcf[k]) * xv(k);
    for (int j = 0; j < NFB; j++) a -= longint'(bcb[j]) * rv(j);
    return sat(a >>> CFRAC);
  endfunction

  function automatic int slice(input int y, input int sel);
    int lim = (2 << sel) - 1;
    int lev = 2 * (y >>> (FRAC + 1)) + 1;
    if (lev > lim) lev = lim;
    if (lev < -lim) lev = -lim;
    return lev * 64;
  endfunction

  function automatic int rsym(input int lvls);
    return 2 * $urandom_range(lvls - 1) - (lvls - 1);
  endfunction

  task automatic binit();
    for (int k = 0; k < NFF; k++) bcf[k] = (k == C) ? 4096 : 0;
    for (int j = 0; j < NFB; j++) bcb[j] = 0;
  endtask

  task automatic step(input int x, input bit tv, input int ts, input bit fz,
                      input bit ini, input bit we, input int wi, input int wd);
    if (started) begin
      xh[idx] = px; rh[idx] = pr; idx++;
    end
    started = 1;
    @(negedge clk);
    x_in = DW'(x); trn_vld = tv; trn_sym = DW'(ts); frz_n = fz;
    init = ini; wr_en = we; wr_idx = IW'(wi); wr_data = CW'(wd);
    #2;
    px = x;
    pr = tv ? ts : int'(dec_out);
    if (ini) binit();
    else if (we) begin
      if (wi < NFF) bcf[wi] = wd; else bcb[wi-NFF] = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    binit();
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #1;
    chk(y_out == 0, "R1 reset output", int'(y_out), 0);
    chk(dec_out == 64, "R3 reset decision", int'(dec_out), 64);

    // R1 R3 R5 R7: frozen pass-through, sweep of input codes in all slicer modes
    for (int sel = 0; sel < 4; sel++) begin
      lvl_sel = 2'(sel);
      for (int x = -2048; x <= 2047; x += 3) begin
        step(x, 0, 0, 0, 0, 0, 0, 0);
        chk(int'(y_out) == xv(C), "R1/R7 pass-through", int'(y_out), xv(C));
        chk(int'(dec_out) == slice(int'(y_out), sel), "R3 slicer", int'(dec_out), slice(int'(y_out), sel));
        chk(int'(err_out) == int'(dec_out) - int'(y_out), "R5 blind error", int'(err_out), int'(dec_out) - int'(y_out));
      end
    end

    // R4: training reference
    lvl_sel = 2'd2;
    for (int i = 0; i < 40; i++) begin
      int ts = 64 * rsym(8);
      step(64 * rsym(16), 1, ts, 0, 0, 0, 0, 0);
      chk(int'(err_out) == ts - int'(y_out), "R4 training error", int'(err_out), ts - int'(y_out));
    end

    // R2 R9: written forward and feedback taps
    step(0, 1, 0, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1, 0, 1024);
    step(0, 1, 0, 0, 0, 1, NFF + 1, -2048);
    step(0, 1, 0, 0, 0, 1, NFF + 2, 1536);
    for (int i = 0; i < 60; i++) begin
      step(64 * rsym(8), 1, 64 * rsym(8), 0, 0, 0, 0, 0);
      if (i >= 4) chk(int'(y_out) == yexp(), "R2/R9 filter sum", int'(y_out), yexp());
    end

    // R10: saturation
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 16384);
    for (int i = 0; i < 8; i++) step(960, 0, 0, 0, 0, 0, 0, 0);
    chk(int'(y_out) == 2047 && yexp() == 2047, "R10 positive saturation", int'(y_out), 2047);
    for (int i = 0; i < 8; i++) step(-960, 0, 0, 0, 0, 0, 0, 0);
    chk(int'(y_out) == -2048 && yexp() == -2048, "R10 negative saturation", int'(y_out), -2048);

    // R6: trained convergence on x = s[n] + 0.5 s[n-1]
    begin
      longint se = 0;
      int n = 0;
      step(0, 0, 0, 0, 1, 0, 0, 0);
      mu_sh = 4'd9;
      for (int i = 0; i < 4000; i++) begin
        int ts;
        sv[i] = rsym(8);
        ts = (i - 1 - C >= 0) ? 64 * sv[i-1-C] : 0;
        step(64 * sv[i] + 32 * ((i > 0) ? sv[i-1] : 0), 1, ts, 1, 0, 0, 0, 0);
        if (i >= 3000) begin
          se += longint'(err_out) * longint'(err_out);
          n++;
        end
      end
      chk(se < 41 * longint'(n) , "R6 mean squared error", int'(se / n), 40);
      // R5: decision-directed tracking after training stops
      for (int i = 4000; i < 4300; i++) begin
        sv[i] = rsym(8);
        step(64 * sv[i] + 32 * sv[i-1], 0, 0, 1, 0, 0, 0, 0);
        chk(int'(dec_out) == 64 * sv[i-1-C], "R5 blind decisions", int'(dec_out), 64 * sv[i-1-C]);
      end
    end

    // R8: init restores pass-through after adaptation
    step(0, 0, 0, 0, 1, 1, 1, 3000);
    for (int i = 0; i < 20; i++) begin
      step(64 * rsym(16), 0, 0, 0, 0, 0, 0, 0);
      chk(int'(y_out) == xv(C), "R8 init restore", int'(y_out), xv(C));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule